// File: doc/BRIEF.md
# Predicate Test Flag Generator

This block turns a pair of vector predicates into a four-bit condition code. One predicate is the governing mask and the other is a result produced elsewhere. Both carry one bit per byte of the vector. The caller picks an element width of 1, 2, 4 or 8 bytes. Each element is then represented by the predicate bit at the lowest byte of its group, and the remaining bits of the group play no part.

The flags do not come from arithmetic. They come from the lowest and highest elements that the mask enables, and from whether any enabled element has its result bit set. A runtime predicate length cuts off the upper part of the predicate, so a shorter active vector can be used without changing the parameter.

A request is presented with `inValid`. The flags appear one clock later together with `outValid`, and they hold their value until the next request.

Top module: `predtest_flags`

## Requirements
- R1: Element e is governed by predicate bit e×B, where B is the element size in bytes selected by `eszCode` (00 = 1, 01 = 2, 10 = 4, 11 = 8). Mask and result bits at other positions of the element's byte group have no effect on the flags.
- R2: Predicate bit positions at or above `predLen` count as inactive, whatever their mask value.
- R3: N is the result bit of the lowest-numbered active element. N is 0 when no element is active.
- R4: Z is 1 exactly when no active element has its result bit set.
- R5: C is the inverse of the result bit of the highest-numbered active element. C is 1 when no element is active.
- R6: V is always 0.
- R7: The output is packed as `nzcv[3]`=N, `nzcv[2]`=Z, `nzcv[1]`=C, `nzcv[0]`=V.
- R8: `outValid` is high in the cycle after `inValid` was high, and only then. The flags update only on a request and otherwise keep their value.
- R9: A synchronous active-high `rst` clears `outValid` and `nzcv` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; inputs are sampled on this cycle |
| maskPred | input | PRED_W | Governing predicate, one bit per byte |
| resPred | input | PRED_W | Result predicate, one bit per byte |
| eszCode | input | 2 | Element size code (00 = 1 byte, 01 = 2, 10 = 4, 11 = 8) |
| predLen | input | LEN_W | Current predicate length in bits; higher bits are inactive |
| outValid | output | 1 | Flags valid, one clock after the request |
| nzcv | output | 4 | Flags N, Z, C, V from bit 3 down to bit 0 |

## Verification
The bench builds the block with `PRED_W` = 16. With that width every element size from one byte to eight bytes produces at least two elements, so the lowest and highest active elements can differ at every granularity. It also lets `predLen` be set both below the full width and to zero. The vectors place set bits inside element groups but off the governing position, so the ignored bits are tested at each size. They also cover the four combinations of a set or clear result at the first and last active element.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture new flags
    logic clear;  // force flags to zero
  } ptfStrobe_t;

  // Flag bit positions inside the nzcv output
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/ptf_pick.sv
// Isolates the lowest or the highest set bit of a vector as a one-hot word.
module ptf_pick #(
  parameter int W         = 32,
  parameter bit PICK_HIGH = 1'b0
) (
  input  logic [W-1:0] vecIn,
  output logic [W-1:0] oneHot
);
  generate
    if (PICK_HIGH) begin : g_high
      logic [W-1:0] revIn;
      logic [W-1:0] revPick;
      always_comb begin
        for (int i = 0; i < W; i++) revIn[i] = vecIn[W-1-i];
      end
      assign revPick = revIn & (~revIn + W'(1));
      always_comb begin
        for (int i = 0; i < W; i++) oneHot[i] = revPick[W-1-i];
      end
    end else begin : g_low
      assign oneHot = vecIn & (~vecIn + W'(1));
    end
  endgenerate
endmodule

// File: rtl/ptf_ctrl.sv
// Control: request tracking and strobe generation.
module ptf_ctrl
  import ptf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output ptfStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/ptf_datapath.sv
// Datapath: active-element selection, first/last search and flag register.
module ptf_datapath
  import ptf_pkg::*;
#(
  parameter int PRED_W = 32,
  parameter int LEN_W  = $clog2(PRED_W + 1)
) (
  input  logic              clk,
  input  ptfStrobe_t        strobe,
  input  logic [PRED_W-1:0] maskPred,
  input  logic [PRED_W-1:0] resPred,
  input  logic [1:0]        eszCode,
  input  logic [LEN_W-1:0]  predLen,
  output logic [3:0]        nzcv
);
  localparam int NUM_SIZES = 4;

  // Governing-bit positions for each element size
  logic [PRED_W-1:0] laneMask [NUM_SIZES];
  genvar gs, gb;
  generate
    for (gs = 0; gs < NUM_SIZES; gs++) begin : g_size
      for (gb = 0; gb < PRED_W; gb++) begin : g_bit
        localparam bit IS_LEAD = ((gb % (1 << gs)) == 0);
        assign laneMask[gs][gb] = IS_LEAD;
      end
    end
  endgenerate

  // Positions inside the current predicate length
  logic [PRED_W-1:0] inRange;
  generate
    for (gb = 0; gb < PRED_W; gb++) begin : g_range
      assign inRange[gb] = (predLen > LEN_W'(gb));
    end
  endgenerate

  logic [PRED_W-1:0] activeVec;
  logic [PRED_W-1:0] hitVec;
  logic [PRED_W-1:0] firstHot;
  logic [PRED_W-1:0] lastHot;

  assign activeVec = maskPred & inRange & laneMask[eszCode];
  assign hitVec    = activeVec & resPred;

  ptf_pick #(.W(PRED_W), .PICK_HIGH(1'b0)) u_first (
    .vecIn  (activeVec),
    .oneHot (firstHot)
  );

  ptf_pick #(.W(PRED_W), .PICK_HIGH(1'b1)) u_last (
    .vecIn  (activeVec),
    .oneHot (lastHot)
  );

  logic [3:0] flagsNext;
  always_comb begin
    flagsNext         = 4'b0000;
    flagsNext[FLAG_N] = |(firstHot & resPred);
    flagsNext[FLAG_Z] = ~(|hitVec);
    flagsNext[FLAG_C] = ~(|(lastHot & resPred));
    flagsNext[FLAG_V] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     nzcv <= 4'b0000;
    else if (strobe.load) nzcv <= flagsNext;
  end
endmodule

// File: rtl/predtest_flags.sv
// Top: predicate test flag generator.
module predtest_flags
  import ptf_pkg::*;
#(
  parameter int PRED_W = 32,
  parameter int LEN_W  = $clog2(PRED_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [PRED_W-1:0] maskPred,
  input  logic [PRED_W-1:0] resPred,
  input  logic [1:0]        eszCode,
  input  logic [LEN_W-1:0]  predLen,
  output logic              outValid,
  output logic [3:0]        nzcv
);
  ptfStrobe_t strobe;

  ptf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ptf_datapath #(.PRED_W(PRED_W), .LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .maskPred (maskPred),
    .resPred  (resPred),
    .eszCode  (eszCode),
    .predLen  (predLen),
    .nzcv     (nzcv)
  );
endmodule

// File: rtl/predtest_flags_chk.sv
module predtest_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       outValid,
  input logic [3:0] nzcv
);
  // R6: V never set
  a_r6_v_zero: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (nzcv[0] == 1'b0));

  // R8: one-cycle latency of the valid strobe
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(nzcv));

  // R3/R4: a set first-active result means some hit, so Z is clear
  a_r3_n_implies_not_z: assert property (@(posedge clk) disable iff (rst)
    (outValid && nzcv[3]) |-> !nzcv[2]);

  // R5/R4: a clear C means the last active result is set, so Z is clear
  a_r5_notc_implies_not_z: assert property (@(posedge clk) disable iff (rst)
    (outValid && !nzcv[1]) |-> !nzcv[2]);

  // R9: reset clears outputs
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && nzcv == 4'b0000));
endmodule

bind predtest_flags predtest_flags_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .nzcv     (nzcv)
);

// File: tb/predtest_flags_bench.sv
module predtest_flags_bench;
  localparam int PW = 16;
  localparam int LW = $clog2(PW + 1);
  localparam int VW = PW + PW + 2 + LW + 4;
  localparam int NV = 11;

  // {mask, result, esz, len, expected nzcv}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'hFFFF, 16'h0001, 2'b00, 5'd16, 4'hA}, // R3 R5 N=1 C=1
    {16'h0000, 16'hFFFF, 2'b00, 5'd16, 4'h6}, // R3 R4 R5 none active
    {16'hFFFF, 16'h8000, 2'b00, 5'd16, 4'h0}, // R5 last set -> C=0
    {16'h0002, 16'h0002, 2'b01, 5'd16, 4'h6}, // R1 odd bit ignored at 2B
    {16'h0110, 16'h0100, 2'b10, 5'd16, 4'h0}, // R1 4B elements
    {16'h0101, 16'h0001, 2'b11, 5'd16, 4'hA}, // R1 8B elements
    {16'hFFFF, 16'hFF00, 2'b00, 5'd8,  4'h6}, // R2 upper half cut
    {16'hFFFF, 16'hFFFF, 2'b00, 5'd0,  4'h6}, // R2 zero length
    {16'h00F0, 16'h0010, 2'b00, 5'd16, 4'hA}, // R3 R5 inner window
    {16'h00F0, 16'h0090, 2'b00, 5'd16, 4'h8}, // R3 R5 N=1 C=0
    {16'hFFFF, 16'h0013, 2'b01, 5'd6,  4'h8}  // R1 R2 2B with length
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [PW-1:0] maskPred = '0;
  logic [PW-1:0] resPred = '0;
  logic [1:0]    eszCode = 2'b00;
  logic [LW-1:0] predLen = '0;
  logic          outValid;
  logic [3:0]    nzcv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  predtest_flags #(.PRED_W(PW)) u_predtest_flags (
    .clk(clk), .rst(rst), .inValid(inValid),
    .maskPred(maskPred), .resPred(resPred),
    .eszCode(eszCode), .predLen(predLen),
    .outValid(outValid), .nzcv(nzcv)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [VW-1:0] v, input string req);
    @(negedge clk);
    {maskPred, resPred, eszCode, predLen} = v[VW-1:4];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    // R7 R6: packed order checked through full nzcv compare
    check(req, {outValid, nzcv}, {1'b1, v[3:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", {outValid, nzcv}, 5'b0_0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("R3/R4/R5 vector %0d", i));

    // R8: flags hold and no valid without a request
    @(negedge clk);
    maskPred = 16'hFFFF; resPred = 16'h8000; eszCode = 2'b00; predLen = 5'd16;
    @(negedge clk);
    check("R8 hold without request", {outValid, nzcv}, {1'b0, 4'h8});

    // R8: back-to-back requests, each answered the next cycle
    @(negedge clk);
    maskPred = 16'hFFFF; resPred = 16'h0000; predLen = 5'd16; inValid = 1'b1;
    @(negedge clk);
    check("R8 first of pair", {outValid, nzcv}, {1'b1, 4'h6});
    maskPred = 16'h0001; resPred = 16'h0001;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 second of pair", {outValid, nzcv}, {1'b1, 4'h8});
    @(negedge clk);
    check("R8 valid drops", {outValid, nzcv}, {1'b0, 4'h8});

    // R1: only lead bit of each 8-byte group counts
    run_vec({16'hFEFE, 16'hFFFF, 2'b11, 5'd16, 4'h6}, "R1 non-lead bits ignored");

    // R9: reset mid-run clears output
    run_vec({16'hFFFF, 16'h0001, 2'b00, 5'd16, 4'hA}, "R3 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears", {outValid, nzcv}, 5'b0_0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule